// File: doc/BRIEF.md
# Host-side serial ADC frame sequencer

This block drives a multi-channel successive-approximation converter from the host side of its serial link. For each accepted request it pulses the convert strobe and waits for the converter's busy line to drop and then rise again. It then lowers the read strobe and clocks one 16-bit frame. In that frame it shifts out an 8-bit command built from the request fields and shifts in the 16-bit result that the converter returns.

The converter answers each frame with the conversion set up by the frame before. The sequencer therefore labels every result with the command that produced it. It suppresses results it knows are meaningless: the first frame after reset, the frame after a busy timeout, and the frame that wakes the converter. It also runs power management. A request whose sleep bit is set puts the sequencer into a resting state that holds the convert strobe still. A wake pulse later raises the strobe, sends the last command with sleep cleared, and holds off new requests for a settling count given on an input.

Top module: `adc_seq_host`

## Requirements
- R1: After reset `req_ready` is 1, `adc_rd_n` is 1, and `adc_sck`, `adc_cnv`, `res_valid`, `tmo_err` and `asleep` are 0.
- R2: An accepted request holds `adc_cnv` high for exactly CNV_CYC cycles. The read strobe falls only after `adc_busy` has been seen low and then high, and never while `adc_cnv` is high.
- R3: A frame keeps `adc_rd_n` low for exactly 16 rising edges of `adc_sck`. The clock rests low outside frames and `adc_sdi` changes only while the clock is low. The command goes MSB first: bit 7 single-ended select, bit 6 odd/sign, bits 5:4 channel select, bit 3 unipolar, bit 2 wide span, bit 1 nap, bit 0 sleep. Eight zero bits follow. The nap bit is sent exactly as requested and adds no sequencing.
- R4: `adc_sdo` is sampled MSB first on each rising `adc_sck`. `res_valid` pulses for one cycle, in the cycle `adc_rd_n` returns high. `res_cmd` then holds the command of the previous frame.
- R5: No `res_valid` follows the first frame after reset, nor the first frame after a busy timeout.
- R6: With RES_BITS of 12 or 14, `res_data` is the captured word shifted right by 16-RES_BITS, with zero upper bits.
- R7: If the busy low-then-high sequence does not finish within TMO_CYC cycles, `tmo_err` pulses for one cycle, no frame is clocked, and `req_ready` returns.
- R8: After a frame whose sleep bit is 1, `asleep` is 1 and `req_ready` is 0. `adc_cnv` does not change, and requests start no convert pulse and no frame.
- R9: `wake_req` while asleep raises `adc_cnv` once and then clocks a frame carrying the last command with its sleep bit cleared. That frame gives no `res_valid`. A `req_valid` in the same cycle is ignored.
- R10: After the wake frame, `req_ready` rises exactly `wake_cycles`+1 cycles after `adc_rd_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_single_end | input | 1 | 1: single-ended input, 0: differential pair |
| req_odd_sign | input | 1 | Odd channel / pair polarity |
| req_chan | input | 2 | Channel or pair select |
| req_unipolar | input | 1 | Unipolar range |
| req_wide | input | 1 | Wide input span |
| req_nap | input | 1 | Nap after conversion |
| req_sleep | input | 1 | Enter sleep after this frame |
| wake_req | input | 1 | Start the wake-up sequence while asleep |
| wake_cycles | input | CNT_W | Settling wait after wake, in cycles |
| adc_cnv | output | 1 | Convert strobe |
| adc_busy | input | 1 | Converter busy line, low while converting |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_sck | output | 1 | Serial clock |
| adc_sdi | output | 1 | Serial command out |
| adc_sdo | input | 1 | Serial result in |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Right-aligned result |
| res_cmd | output | 8 | Command the result belongs to |
| tmo_err | output | 1 | Busy timeout pulse |
| asleep | output | 1 | Converter is in sleep |

## Verification
A wake pulse and a conversion request can reach a sleeping sequencer in the same cycle. The bench raises `wake_req` and `req_valid` together on one negative edge, giving the request command fields that differ from the stored command. It then judges the wake frame by what the converter model received: the stored command with sleep cleared. It also checks that only one convert pulse occurred, that no result strobe appeared, and that the settling wait before `req_ready` returns was exact.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 8;

    // Bit order is decoded by the converter; MSB leaves first.
    typedef struct packed {
        logic       single_end;
        logic       odd_sign;
        logic [1:0] chan_sel;
        logic       unipolar;
        logic       wide_span;
        logic       nap;
        logic       sleep;
    } adc_cmd_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CNV,
        S_WAIT_LO,
        S_WAIT_HI,
        S_FRAME,
        S_SLEEP,
        S_WAKE_CNV,
        S_WAKE_FRAME,
        S_SETTLE
    } seq_state_e;

    function automatic logic [FRAME_BITS-1:0] build_frame(input adc_cmd_t cmd);
        return {cmd, {(FRAME_BITS-CMD_BITS){1'b0}}};
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
    parameter int SCK_HALF   = 2,
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  sdo_i,
    output logic                  active,
    output logic                  sck_o,
    output logic                  sdi_o,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_word
);
    localparam int PH_W  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SCK_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    logic [PH_W-1:0]       phase_q;
    logic [BIT_W-1:0]      bit_q;
    logic                  sck_q;
    logic                  act_q;
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic                  ph_end;

    assign ph_end = (phase_q == PH_LAST);
    assign done   = act_q && ph_end && sck_q && (bit_q == BIT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            bit_q   <= '0;
            sck_q   <= 1'b0;
            act_q   <= 1'b0;
            tx_q    <= '0;
            rx_q    <= '0;
        end else if (start && !act_q) begin
            act_q   <= 1'b1;
            phase_q <= '0;
            bit_q   <= '0;
            sck_q   <= 1'b0;
            tx_q    <= tx_word;
        end else if (act_q) begin
            if (!ph_end) begin
                phase_q <= phase_q + 1'b1;
            end else begin
                phase_q <= '0;
                if (!sck_q) begin
                    // rising edge: converter samples SDI, host samples SDO
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[FRAME_BITS-2:0], sdo_i};
                end else begin
                    // falling edge: next command bit goes out
                    sck_q <= 1'b0;
                    tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
                    if (bit_q == BIT_LAST) begin
                        act_q <= 1'b0;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
            end
        end
    end

    assign active  = act_q;
    assign sck_o   = sck_q;
    assign sdi_o   = tx_q[FRAME_BITS-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 16,
    parameter int SCK_HALF = 2,
    parameter int CNV_CYC  = 3,
    parameter int TMO_CYC  = 256,
    parameter int CNT_W    = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_single_end,
    input  logic             req_odd_sign,
    input  logic [1:0]       req_chan,
    input  logic             req_unipolar,
    input  logic             req_wide,
    input  logic             req_nap,
    input  logic             req_sleep,
    input  logic             wake_req,
    input  logic [CNT_W-1:0] wake_cycles,
    output logic             adc_cnv,
    input  logic             adc_busy,
    output logic             adc_rd_n,
    output logic             adc_sck,
    output logic             adc_sdi,
    input  logic             adc_sdo,
    output logic             res_valid,
    output logic [15:0]      res_data,
    output logic [7:0]       res_cmd,
    output logic             tmo_err,
    output logic             asleep
);
    localparam int DROP_BITS = FRAME_BITS - RES_BITS;
    localparam logic [CNT_W-1:0] CNV_LOAD = CNT_W'(CNV_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LOAD = CNT_W'(TMO_CYC - 1);

    seq_state_e state_q, state_d;
    adc_cmd_t   cur_cmd_q, last_cmd_q;
    logic       prev_ok_q;
    logic       tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic       sh_start, sh_active, sh_done;
    logic       tmo_hit;
    logic       take_req, take_wake;
    logic [FRAME_BITS-1:0] rx_word, aligned;

    adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    adc_seq_shifter #(.SCK_HALF(SCK_HALF), .FRAME_BITS(FRAME_BITS)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_word (build_frame(cur_cmd_q)),
        .sdo_i   (adc_sdo),
        .active  (sh_active),
        .sck_o   (adc_sck),
        .sdi_o   (adc_sdi),
        .done    (sh_done),
        .rx_word (rx_word)
    );

    generate
        if (DROP_BITS == 0) begin : g_full
            assign aligned = rx_word;
        end else begin : g_trim
            assign aligned = rx_word >> DROP_BITS;
        end
    endgenerate

    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tmr_dec   = 1'b0;
        sh_start  = 1'b0;
        tmo_hit   = 1'b0;
        take_req  = 1'b0;
        take_wake = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    take_req = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNV_LOAD;
                    state_d  = S_CNV;
                end
            end
            S_CNV: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMO_LOAD;
                    state_d  = S_WAIT_LO;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            S_WAIT_LO: begin
                tmr_dec = 1'b1;
                if (tmr_zero) begin
                    tmo_hit = 1'b1;
                    state_d = S_IDLE;
                end else if (!adc_busy) begin
                    state_d = S_WAIT_HI;
                end
            end
            S_WAIT_HI: begin
                tmr_dec = 1'b1;
                if (adc_busy) begin
                    sh_start = 1'b1;
                    state_d  = S_FRAME;
                end else if (tmr_zero) begin
                    tmo_hit = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_FRAME: begin
                if (sh_done) begin
                    state_d = cur_cmd_q.sleep ? S_SLEEP : S_IDLE;
                end
            end
            S_SLEEP: begin
                if (wake_req) begin
                    take_wake = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNV_LOAD;
                    state_d   = S_WAKE_CNV;
                end
            end
            S_WAKE_CNV: begin
                if (tmr_zero) begin
                    sh_start = 1'b1;
                    state_d  = S_WAKE_FRAME;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            S_WAKE_FRAME: begin
                if (sh_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = wake_cycles;
                    state_d  = S_SETTLE;
                end
            end
            S_SETTLE: begin
                if (tmr_zero) begin
                    state_d = S_IDLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            cur_cmd_q  <= '0;
            last_cmd_q <= '0;
            prev_ok_q  <= 1'b0;
            res_valid  <= 1'b0;
            res_data   <= '0;
            res_cmd    <= '0;
            tmo_err    <= 1'b0;
        end else begin
            state_q   <= state_d;
            res_valid <= 1'b0;
            tmo_err   <= tmo_hit;
            if (take_req) begin
                cur_cmd_q <= adc_cmd_t'({req_single_end, req_odd_sign, req_chan,
                                         req_unipolar, req_wide, req_nap, req_sleep});
            end
            if (take_wake) begin
                cur_cmd_q       <= last_cmd_q;
                cur_cmd_q.sleep <= 1'b0;
            end
            if (tmo_hit) begin
                prev_ok_q <= 1'b0;
            end
            if (sh_done) begin
                last_cmd_q <= cur_cmd_q;
                prev_ok_q  <= 1'b1;
                if (prev_ok_q && (state_q == S_FRAME)) begin
                    res_valid <= 1'b1;
                    res_data  <= aligned;
                    res_cmd   <= last_cmd_q;
                end
            end
        end
    end

    assign req_ready = (state_q == S_IDLE);
    assign asleep    = (state_q == S_SLEEP);
    assign adc_cnv   = (state_q == S_CNV) || (state_q == S_WAKE_CNV);
    assign adc_rd_n  = ~sh_active;
endmodule

// File: rtl/adc_seq_host_chk.sv
module adc_seq_host_chk (
    input logic clk,
    input logic rst,
    input logic adc_cnv,
    input logic adc_rd_n,
    input logic adc_sck,
    input logic adc_sdi,
    input logic res_valid,
    input logic tmo_err,
    input logic asleep
);
    // R3: clock rests low outside a frame
    a_r3_sck_idle_outside_frame: assert property (@(posedge clk) disable iff (rst)
        adc_rd_n |-> !adc_sck);

    // R3: command bit moves only while the serial clock is low
    a_r3_sdi_moves_while_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(adc_sdi) |-> !adc_sck);

    // R2: convert strobe and read strobe never overlap
    a_r2_no_read_during_cnv: assert property (@(posedge clk) disable iff (rst)
        adc_cnv |-> adc_rd_n);

    // R4: result strobe coincides with the end of the read strobe
    a_r4_result_with_read_end: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $rose(adc_rd_n));

    // R7: timeout is a single pulse outside any frame
    a_r7_err_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tmo_err |=> !tmo_err);

    a_r7_err_no_frame: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> adc_rd_n);

    // R8: convert strobe held still while asleep
    a_r8_cnv_static_in_sleep: assert property (@(posedge clk) disable iff (rst)
        (asleep && $past(asleep)) |-> $stable(adc_cnv));
endmodule

bind adc_seq_host adc_seq_host_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_cnv   (adc_cnv),
    .adc_rd_n  (adc_rd_n),
    .adc_sck   (adc_sck),
    .adc_sdi   (adc_sdi),
    .res_valid (res_valid),
    .tmo_err   (tmo_err),
    .asleep    (asleep)
);

// File: tb/adc_seq_host_tb.sv
module adc_seq_host_tb;
    localparam int CNV_CYC = 3;
    localparam int TMO_CYC = 64;
    localparam int CONV_T  = 10;
    localparam int WAKE_W  = 200;
    localparam int NVEC    = 6;

    // command vectors: {single_end, odd_sign, chan[1:0], unipolar, wide, nap, sleep}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_0_00_0_0_0_0, 8'b0_1_01_1_0_1_0, 8'b1_1_11_0_1_1_0,
        8'b0_0_10_1_1_0_0, 8'b1_0_01_1_1_1_0, 8'b0_1_11_0_0_0_0 };
    localparam logic [7:0] SLP_CMD = 8'b1_0_10_0_1_0_1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_single_end = 1'b0, req_odd_sign = 1'b0, req_unipolar = 1'b0;
    logic req_wide = 1'b0, req_nap = 1'b0, req_sleep = 1'b0;
    logic [1:0] req_chan = 2'b00;
    logic wake_req = 1'b0;
    logic [23:0] wake_cycles = 24'(WAKE_W);
    logic req_ready, adc_cnv, adc_rd_n, adc_sck, adc_sdi, res_valid, tmo_err, asleep;
    logic [15:0] res_data;
    logic [7:0]  res_cmd;
    logic req_ready12, adc_cnv12, adc_rd_n12, adc_sck12, adc_sdi12, res_valid12, tmo_err12, asleep12;
    logic [15:0] res_data12;
    logic [7:0]  res_cmd12;

    always #2 clk = ~clk;

    // converter model
    logic        busy_m = 1'b1;
    logic        stuck = 1'b0;
    logic [15:0] sdo_sh = '0, res_reg = '0, in_word = '0;
    logic [7:0]  cfg_lat = '0;
    logic        p_sck = 1'b0, p_rd = 1'b1, p_cnv = 1'b0;
    int conv_left = 0;
    int vcnt = 0, cnv_rises = 0, rd_falls = 0, err_cnt = 0;
    int sck_cnt = 0, last_sck_cnt = 0, cnv_w = 0, last_cnv_w = 0;
    logic busy_at_rd = 1'b0;
    logic [15:0] last_data = '0, last_data12 = '0;
    logic [7:0]  last_cmd = '0;
    wire adc_sdo = sdo_sh[15];

    always @(posedge clk) begin
        p_sck <= adc_sck;
        p_rd  <= adc_rd_n;
        p_cnv <= adc_cnv;
        if (adc_sck && !p_sck) begin
            in_word <= {in_word[14:0], adc_sdi};
            sck_cnt = sck_cnt + 1;
        end
        if (!adc_sck && p_sck) sdo_sh <= {sdo_sh[14:0], 1'b0};
        if (!adc_rd_n && p_rd) begin
            sdo_sh <= res_reg;
            rd_falls = rd_falls + 1;
            busy_at_rd = busy_m;
        end
        if (adc_rd_n && !p_rd) begin
            cfg_lat <= in_word[15:8];
            last_sck_cnt = sck_cnt;
            sck_cnt = 0;
        end
        if (adc_cnv) cnv_w = cnv_w + 1;
        if (!adc_cnv && p_cnv) begin
            last_cnv_w = cnv_w;
            cnv_w = 0;
        end
        if (adc_cnv && !p_cnv) begin
            cnv_rises = cnv_rises + 1;
            if (!stuck) begin
                busy_m    <= 1'b0;
                conv_left <= CONV_T;
            end
        end else if (conv_left > 0) begin
            conv_left <= conv_left - 1;
            if (conv_left == 1) begin
                busy_m  <= 1'b1;
                res_reg <= {cfg_lat, ~cfg_lat};
            end
        end
        if (res_valid) begin
            vcnt = vcnt + 1;
            last_data = res_data;
            last_cmd  = res_cmd;
        end
        if (res_valid12) last_data12 = res_data12;
        if (tmo_err) err_cnt = err_cnt + 1;
    end

    adc_seq_host #(.RES_BITS(16), .CNV_CYC(CNV_CYC), .TMO_CYC(TMO_CYC)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_single_end(req_single_end), .req_odd_sign(req_odd_sign), .req_chan(req_chan),
        .req_unipolar(req_unipolar), .req_wide(req_wide), .req_nap(req_nap), .req_sleep(req_sleep),
        .wake_req(wake_req), .wake_cycles(wake_cycles),
        .adc_cnv(adc_cnv), .adc_busy(busy_m), .adc_rd_n(adc_rd_n), .adc_sck(adc_sck),
        .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
        .res_valid(res_valid), .res_data(res_data), .res_cmd(res_cmd),
        .tmo_err(tmo_err), .asleep(asleep)
    );

    adc_seq_host #(.RES_BITS(12), .CNV_CYC(CNV_CYC), .TMO_CYC(TMO_CYC)) u_dut12 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready12),
        .req_single_end(req_single_end), .req_odd_sign(req_odd_sign), .req_chan(req_chan),
        .req_unipolar(req_unipolar), .req_wide(req_wide), .req_nap(req_nap), .req_sleep(req_sleep),
        .wake_req(wake_req), .wake_cycles(wake_cycles),
        .adc_cnv(adc_cnv12), .adc_busy(busy_m), .adc_rd_n(adc_rd_n12), .adc_sck(adc_sck12),
        .adc_sdi(adc_sdi12), .adc_sdo(adc_sdo),
        .res_valid(res_valid12), .res_data(res_data12), .res_cmd(res_cmd12),
        .tmo_err(tmo_err12), .asleep(asleep12)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_cmd(input logic [7:0] c);
        {req_single_end, req_odd_sign, req_chan, req_unipolar, req_wide, req_nap, req_sleep} = c;
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        drive_cmd(c);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_frame_end();
        while (adc_rd_n) @(negedge clk);
        while (!adc_rd_n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v0, cr, rf, e0, k;
        logic [7:0] wcmd;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", req_ready, 1);
        chk("R1 rd_n", adc_rd_n, 1);
        chk("R1 sck/cnv", {adc_sck, adc_cnv}, 0);
        chk("R1 valid/err/asleep", {res_valid, tmo_err, asleep}, 0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            v0 = vcnt;
            send(VEC[i]);
            wait_frame_end();
            repeat (2) @(negedge clk);
            chk("R3 command received", cfg_lat, VEC[i]);
            chk("R3 trailing zero bits", in_word[7:0], 0);
            chk("R3 sck count", last_sck_cnt, 16);
            chk("R2 cnv width", last_cnv_w, CNV_CYC);
            chk("R2 busy high at read", busy_at_rd, 1);
            if (i == 0) begin
                chk("R5 no result after reset", vcnt - v0, 0);
            end else begin
                chk("R4 result strobe", vcnt - v0, 1);
                chk("R4 result command", last_cmd, VEC[i-1]);
                chk("R4 result data", last_data, {VEC[i-1], ~VEC[i-1]});
                chk("R6 12-bit alignment", last_data12, {VEC[i-1], ~VEC[i-1]} >> 4);
            end
        end

        // R8 sleep entry
        v0 = vcnt;
        send(SLP_CMD);
        wait_frame_end();
        @(negedge clk);
        chk("R4 result before sleep", vcnt - v0, 1);
        chk("R8 sleep command sent", cfg_lat, SLP_CMD);
        chk("R8 asleep", asleep, 1);
        chk("R8 not ready", req_ready, 0);
        cr = cnv_rises;
        rf = rd_falls;
        drive_cmd(VEC[2]);
        req_valid = 1'b1;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8 no cnv while asleep", cnv_rises - cr, 0);
        chk("R8 no frame while asleep", rd_falls - rf, 0);
        chk("R8 still asleep", asleep, 1);

        // R9 wake with a request in the same cycle; R10 settle
        v0 = vcnt;
        wcmd = SLP_CMD & 8'hFE;
        drive_cmd(8'b0_1_00_1_0_0_0);
        wake_req = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        req_valid = 1'b0;
        wait_frame_end();
        k = 0;
        while (!req_ready) begin
            @(negedge clk);
            k++;
        end
        chk("R10 settle length", k, WAKE_W + 1);
        chk("R9 wake command", cfg_lat, wcmd);
        chk("R9 wake result suppressed", vcnt - v0, 0);
        chk("R9 single cnv rise", cnv_rises - cr, 1);
        chk("R9 awake", asleep, 0);
        v0 = vcnt;
        send(VEC[0]);
        wait_frame_end();
        repeat (2) @(negedge clk);
        chk("R9 first result after wake", vcnt - v0, 1);
        chk("R9 result tagged with wake command", last_cmd, wcmd);
        chk("R9 result data after wake", last_data, {wcmd, ~wcmd});

        // R7 timeout
        stuck = 1'b1;
        e0 = err_cnt;
        rf = rd_falls;
        send(VEC[3]);
        repeat (150) @(negedge clk);
        chk("R7 one timeout pulse", err_cnt - e0, 1);
        chk("R7 no frame on timeout", rd_falls - rf, 0);
        chk("R7 ready again", req_ready, 1);
        stuck = 1'b0;

        // R5 result after timeout suppressed, then resumes
        v0 = vcnt;
        send(VEC[1]);
        wait_frame_end();
        repeat (2) @(negedge clk);
        chk("R5 no result after timeout", vcnt - v0, 0);
        send(VEC[2]);
        wait_frame_end();
        repeat (2) @(negedge clk);
        chk("R5 results resume", vcnt - v0, 1);
        chk("R4 command after timeout", last_cmd, VEC[1]);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule